// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the write-side command interpreter of a NOR-style parallel flash slave. Every bus write reaches it as one byte of data with the byte address it targets. From the order and contents of those writes it recognises the two-write unlock handshake, the command byte that follows, and the command's operands. It reports the resulting operating mode on a small encoded output and fires single-cycle strobes. The strobes start a program, a chip erase or a sector erase, or suspend or resume an erase.

The storage array, the erase timers and the read-data multiplexer sit outside the block. The array supplies the current contents of the addressed location during a program write, so that the block can form the new value. The erase controller reports back through three status inputs: a pulse when an erase finishes, a level that is high while more sector-erase commands may still be queued, and a level that is high while a suspended erase exists. An unlock-bypass flag shortens repeated programming to two writes per byte. Two entry paths into the parameter-query mode differ in where a reset command leads.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst` is high, at the following clock edge `mode` becomes 0 (read), `bypass_on` becomes 0 and every strobe is low.
- R2: Addresses are compared on an 11-bit word index: the byte address is shifted right by 0, 1 or 2 for 1-, 2- or 4-byte devices (`DEV_BYTES`) and only the low 11 bits are kept. An unlock is data 0xAA at index `UNLOCK0`, then data 0x55 at index `UNLOCK1`. Any other write at either step returns to read mode and clears bypass.
- R3: The command write that follows an unlock is checked against index `UNLOCK0` (unless bypass is on). Its data selects the mode: 0xA0 program (`mode`=1), 0x90 autoselect (`mode`=2), 0x80 erase set-up (`mode` stays 0), 0x20 bypass. Any other value returns to read mode.
- R4: In program mode the next write of any data, 0xF0 included, gives `prog_stb` high for one cycle, in the cycle after the write. With it come `prog_addr` equal to the write address and `prog_wdata` equal to the bitwise AND of `prog_cur` and the written data. The mode then returns to read, or to the command step if bypass is on.
- R5: Data 0x20 at the command step sets `bypass_on` and stays at the command step, where the address is then no longer checked. Writing 0x00 in autoselect mode while bypass is on returns to read and clears bypass.
- R6: After 0x80, a second unlock pair and then 0x10 at `UNLOCK0` fires `chip_erase_stb` and enters `mode`=4. Instead of 0x10, 0x30 at any address fires `sector_erase_stb`, loads `erase_addr` and enters `mode`=5. Any other write at that step, or either command while `erase_suspended` is high, returns to read.
- R7: Data 0xF0 returns to read and clears bypass in every state except program, chip erase and sector erase, where it is not treated as a reset. From the query mode entered through autoselect, 0xF0 goes back to autoselect instead.
- R8: In read mode, 0x98 at word index 0x55 enters query mode (`mode`=3). The same write in autoselect enters the autoselect-query state (also `mode`=3). Any write other than 0xF0 in either query state returns to read.
- R9: In read mode, 0xB0 changes nothing. 0x30 with `erase_suspended` high fires `resume_stb` and enters `mode`=5. With `erase_suspended` low, 0x30 returns to read and fires no strobe.
- R10: In sector-erase mode, 0xB0 fires `suspend_stb` and returns to read with bypass kept. While `erase_window` is high, 0x30 fires another `sector_erase_stb` and any other data returns to read. While it is low, all other writes are ignored. An `erase_done` pulse returns to read, or to the command step if bypass is on.
- R11: In chip-erase mode every write is ignored, and `erase_done` returns to read, or to the command step if bypass is on.
- R12: A cycle with neither `wr_valid` nor `erase_done` leaves the mode and the bypass flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command or program data byte |
| prog_cur | input | 8 | Current array contents at `wr_addr` |
| erase_done | input | 1 | Pulse: the running erase has finished |
| erase_window | input | 1 | High while more sector commands are accepted |
| erase_suspended | input | 1 | High while a suspended erase exists |
| mode | output | 3 | 0 read, 1 program, 2 autoselect, 3 query, 4 chip erase, 5 sector erase |
| bypass_on | output | 1 | Unlock bypass active |
| prog_stb | output | 1 | Program strobe |
| prog_addr | output | ADDR_W | Program byte address |
| prog_wdata | output | 8 | Value to store (old AND new) |
| chip_erase_stb | output | 1 | Chip erase start strobe |
| sector_erase_stb | output | 1 | Sector erase start strobe |
| erase_addr | output | ADDR_W | Address inside the sector to erase |
| suspend_stb | output | 1 | Erase suspend strobe |
| resume_stb | output | 1 | Erase resume strobe |

## Verification
The assertions check on every cycle the relations that hold across all traffic. Reset leaves the block in read mode without bypass, and the state rests when no write or finish pulse arrives. At most one strobe fires at a time, and each erase strobe follows a write carrying its command byte. A program value never sets a bit the written data had clear, and a program always leaves program mode. Chip erase is left only on a finish pulse. Only the bench's scenarios can show the command-sequence behaviour: which write orders are accepted or rejected, the address aliasing above 11 bits, the two query exits, the bypass round trip, and the suspend and resume handshakes with the erase controller.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int IDX_W = 11;

  localparam logic [7:0] D_UNL0   = 8'hAA;
  localparam logic [7:0] D_UNL1   = 8'h55;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_AUTO   = 8'h90;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_BYPASS = 8'h20;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_SUSP   = 8'hB0;
  localparam logic [7:0] D_QUERY  = 8'h98;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_BYPEXT = 8'h00;
  localparam logic [IDX_W-1:0] QUERY_IDX = 11'h055;

  typedef enum logic [2:0] {
    MD_READ = 3'd0, MD_PROG = 3'd1, MD_AUTO = 3'd2,
    MD_QUERY = 3'd3, MD_CHIP = 3'd4, MD_SECT = 3'd5
  } mode_t;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_EUNL0, ST_EUNL1, ST_ECMD,
    ST_PROG, ST_AUTO, ST_QRY, ST_AQRY, ST_CHIP, ST_SECT
  } seq_st_t;

  function automatic int idx_shift(input int dev_bytes);
    return (dev_bytes >= 4) ? 2 : ((dev_bytes == 2) ? 1 : 0);
  endfunction

  function automatic mode_t mode_of(input seq_st_t s);
    case (s)
      ST_PROG:          return MD_PROG;
      ST_AUTO:          return MD_AUTO;
      ST_QRY, ST_AQRY:  return MD_QUERY;
      ST_CHIP:          return MD_CHIP;
      ST_SECT:          return MD_SECT;
      default:          return MD_READ;
    endcase
  endfunction

  function automatic logic [7:0] prog_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

endpackage

// File: rtl/flash_addr_match.sv
module flash_addr_match
  import flash_seq_pkg::*;
#(
  parameter int SHIFT = 1,
  parameter logic [IDX_W-1:0] UNLOCK0 = 11'h555,
  parameter logic [IDX_W-1:0] UNLOCK1 = 11'h2AA,
  localparam int IN_W = IDX_W + SHIFT
) (
  input  logic [IN_W-1:0]  addr_lo,
  output logic [IDX_W-1:0] widx,
  output logic             hit_u0,
  output logic             hit_u1,
  output logic             hit_q
);
  generate
    if (SHIFT == 0) begin : g_byte
      assign widx = addr_lo;
    end else begin : g_wide
      logic unused_lo;
      assign unused_lo = ^addr_lo[SHIFT-1:0];
      assign widx = addr_lo[IN_W-1:SHIFT];
    end
  endgenerate

  assign hit_u0 = (widx == UNLOCK0);
  assign hit_u1 = (widx == UNLOCK1);
  assign hit_q  = (widx == QUERY_IDX);
endmodule

// File: rtl/flash_seq_core.sv
module flash_seq_core
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        prog_cur,
  input  logic              hit_u0,
  input  logic              hit_u1,
  input  logic              hit_q,
  input  logic              erase_done,
  input  logic              erase_window,
  input  logic              erase_suspended,
  output seq_st_t           st,
  output logic              byp,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_wdata,
  output logic              chip_stb,
  output logic              sect_stb,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              susp_stb,
  output logic              res_stb
);
  seq_st_t nxt_st;
  logic nxt_byp, drop_all;
  logic ev_prog, ev_chip, ev_sect, ev_susp, ev_res;
  logic is_reset_cmd, erase_busy;

  assign erase_busy   = (st == ST_CHIP) || (st == ST_SECT);
  assign is_reset_cmd = (wr_data == D_RESET) && (st != ST_PROG) && !erase_busy;

  always_comb begin
    nxt_st = st; nxt_byp = byp; drop_all = 1'b0;
    ev_prog = 1'b0; ev_chip = 1'b0; ev_sect = 1'b0; ev_susp = 1'b0; ev_res = 1'b0;
    if (erase_busy && erase_done) begin
      nxt_st = byp ? ST_CMD : ST_READ;
    end else if (wr_valid) begin
      if (is_reset_cmd) begin
        if (st == ST_AQRY) nxt_st = ST_AUTO;
        else drop_all = 1'b1;
      end else begin
        case (st)
          ST_READ: begin
            if (hit_q && wr_data == D_QUERY) nxt_st = ST_QRY;
            else if (wr_data == D_SECT) begin
              if (erase_suspended) begin nxt_st = ST_SECT; ev_res = 1'b1; end
              else drop_all = 1'b1;
            end else if (wr_data == D_SUSP) nxt_st = ST_READ;
            else if (hit_u0 && wr_data == D_UNL0) nxt_st = ST_UNL1;
            else drop_all = 1'b1;
          end
          ST_UNL1:  if (hit_u1 && wr_data == D_UNL1) nxt_st = ST_CMD; else drop_all = 1'b1;
          ST_CMD: begin
            if (!byp && !hit_u0) drop_all = 1'b1;
            else case (wr_data)
              D_BYPASS: nxt_byp = 1'b1;
              D_ERASE:  nxt_st = ST_EUNL0;
              D_AUTO:   nxt_st = ST_AUTO;
              D_PROG:   nxt_st = ST_PROG;
              default:  drop_all = 1'b1;
            endcase
          end
          ST_EUNL0: if (hit_u0 && wr_data == D_UNL0) nxt_st = ST_EUNL1; else drop_all = 1'b1;
          ST_EUNL1: if (hit_u1 && wr_data == D_UNL1) nxt_st = ST_ECMD; else drop_all = 1'b1;
          ST_ECMD: begin
            if (erase_suspended) drop_all = 1'b1;
            else if (wr_data == D_CHIP && hit_u0) begin nxt_st = ST_CHIP; ev_chip = 1'b1; end
            else if (wr_data == D_SECT) begin nxt_st = ST_SECT; ev_sect = 1'b1; end
            else drop_all = 1'b1;
          end
          ST_PROG: begin
            ev_prog = 1'b1;
            nxt_st  = byp ? ST_CMD : ST_READ;
          end
          ST_AUTO: begin
            if (byp && wr_data == D_BYPEXT) drop_all = 1'b1;
            else if (hit_q && wr_data == D_QUERY) nxt_st = ST_AQRY;
            else drop_all = 1'b1;
          end
          ST_SECT: begin
            if (wr_data == D_SUSP) begin nxt_st = ST_READ; ev_susp = 1'b1; end
            else if (erase_window) begin
              if (wr_data == D_SECT) ev_sect = 1'b1;
              else drop_all = 1'b1;
            end
          end
          ST_CHIP: nxt_st = ST_CHIP;
          default: drop_all = 1'b1;
        endcase
      end
    end
    if (drop_all) begin nxt_st = ST_READ; nxt_byp = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_READ; byp <= 1'b0;
      prog_stb <= 1'b0; chip_stb <= 1'b0; sect_stb <= 1'b0;
      susp_stb <= 1'b0; res_stb <= 1'b0;
      prog_addr <= '0; prog_wdata <= '0; erase_addr <= '0;
    end else begin
      st <= nxt_st; byp <= nxt_byp;
      prog_stb <= ev_prog; chip_stb <= ev_chip; sect_stb <= ev_sect;
      susp_stb <= ev_susp; res_stb <= ev_res;
      if (ev_prog) begin
        prog_addr  <= wr_addr;
        prog_wdata <= prog_merge(prog_cur, wr_data);
      end
      if (ev_sect) erase_addr <= wr_addr;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) && !rst |-> (st == ST_READ) && !byp); // R1
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(wr_valid) && !$past(erase_done) |-> $stable(st) && $stable(byp)); // R12
  AST_CHIP_CMD: assert property (@(posedge clk) disable iff (rst)
    chip_stb |-> $past(wr_valid) && $past(wr_data) == D_CHIP); // R6
  AST_SECT_CMD: assert property (@(posedge clk) disable iff (rst)
    sect_stb |-> $past(wr_valid) && $past(wr_data) == D_SECT && st == ST_SECT); // R10
  AST_CHIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHIP) && !erase_done |=> st == ST_CHIP); // R11
  AST_PROG_LEAVES: assert property (@(posedge clk) disable iff (rst)
    prog_stb |-> st != ST_PROG); // R4
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DEV_BYTES = 2,
  parameter logic [IDX_W-1:0] UNLOCK0 = 11'h555,
  parameter logic [IDX_W-1:0] UNLOCK1 = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        prog_cur,
  input  logic              erase_done,
  input  logic              erase_window,
  input  logic              erase_suspended,
  output logic [2:0]        mode,
  output logic              bypass_on,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_wdata,
  output logic              chip_erase_stb,
  output logic              sector_erase_stb,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              suspend_stb,
  output logic              resume_stb
);
  localparam int SH   = idx_shift(DEV_BYTES);
  localparam int LO_W = IDX_W + SH;

  logic [IDX_W-1:0] widx;
  logic hit_u0, hit_u1, hit_q;
  seq_st_t st;

  flash_addr_match #(.SHIFT(SH), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_match (
    .addr_lo(wr_addr[LO_W-1:0]), .widx(widx),
    .hit_u0(hit_u0), .hit_u1(hit_u1), .hit_q(hit_q)
  );

  flash_seq_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_cur(prog_cur),
    .hit_u0(hit_u0), .hit_u1(hit_u1), .hit_q(hit_q),
    .erase_done(erase_done), .erase_window(erase_window),
    .erase_suspended(erase_suspended),
    .st(st), .byp(bypass_on),
    .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .chip_stb(chip_erase_stb), .sect_stb(sector_erase_stb),
    .erase_addr(erase_addr), .susp_stb(suspend_stb), .res_stb(resume_stb)
  );

  assign mode = mode_of(st);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb})); // R4
  AST_PROG_NO_SET: assert property (@(posedge clk) disable iff (rst)
    prog_stb |-> (prog_wdata & ~$past(wr_data)) == 8'h00); // R4
  AST_RESUME_SECT: assert property (@(posedge clk) disable iff (rst)
    resume_stb |-> mode == 3'd5); // R9
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 24;
  localparam logic [AW-1:0] U0 = 24'h000AAA, U1 = 24'h000554, QA = 24'h0000AA;

  logic clk = 0, rst = 1, wr_valid = 0, erase_done = 0, erase_window = 0, erase_suspended = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, prog_cur = '0;
  logic [2:0] mode;
  logic bypass_on, prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [7:0] prog_wdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DEV_BYTES(2)) u_dut (.*);

  typedef struct {
    logic [2:0] m; logic b; logic [4:0] s;
    logic [AW-1:0] pa; logic [7:0] pd; logic [AW-1:0] ea; string tag;
  } exp_t;
  exp_t q[$];
  logic took;

  task automatic step(input bit v, input bit dn, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [7:0] old, input logic [2:0] m, input bit b, input logic [4:0] s,
                      input logic [AW-1:0] xa, input logic [7:0] xd, input string tag);
    exp_t e;
    e.m = m; e.b = b; e.s = s; e.pa = xa; e.pd = xd; e.ea = xa; e.tag = tag;
    q.push_back(e);
    wr_valid = v; erase_done = dn; wr_addr = a; wr_data = d; prog_cur = old;
    @(negedge clk);
    wr_valid = 0; erase_done = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [2:0] m,
                    input bit b, input string tag);
    step(1, 0, a, d, 8'hFF, m, b, 5'b0, '0, 8'h0, tag);
  endtask

  task automatic unl(input bit b);
    wr(U0, 8'hAA, 3'd0, b, "R2 unlock0");
    wr(U1, 8'h55, 3'd0, b, "R2 unlock1");
  endtask

  // monitor: compares each result in the cycle after the event that caused it
  always @(posedge clk) begin
    took = wr_valid | erase_done;
    #2;
    if (took && q.size() > 0) begin
      exp_t e;
      logic [4:0] s;
      logic bad;
      e = q.pop_front();
      s = {prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb};
      bad = (mode !== e.m) || (bypass_on !== e.b) || (s !== e.s);
      if (e.s[4] && (prog_addr !== e.pa || prog_wdata !== e.pd)) bad = 1;
      if (e.s[2] && erase_addr !== e.ea) bad = 1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: mode=%0d byp=%0b stb=%b pa=%h pd=%h ea=%h expected mode=%0d byp=%0b stb=%b addr=%h pd=%h",
                 e.tag, mode, bypass_on, s, prog_addr, prog_wdata, erase_addr,
                 e.m, e.b, e.s, e.pa, e.pd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== 3'd0 || bypass_on !== 1'b0 ||
        {prog_stb, chip_erase_stb, sector_erase_stb, suspend_stb, resume_stb} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset: mode=%0d byp=%0b expected mode=0 byp=0", mode, bypass_on);
    end
    rst = 0;
    @(negedge clk);

    // R3 R4: plain program
    unl(0);
    wr(U0, 8'hA0, 3'd1, 0, "R3 program select");
    step(1, 0, 24'h000100, 8'h3C, 8'hF5, 3'd0, 0, 5'b10000, 24'h000100, 8'h34, "R4 program merge");

    // R2: bad second unlock, then an unlocked-looking command is refused
    wr(U0, 8'hAA, 3'd0, 0, "R2 unlock0");
    wr(24'h000556, 8'h55, 3'd0, 0, "R2 wrong unlock1 address");
    wr(U0, 8'hA0, 3'd0, 0, "R2 no command after bad unlock");
    wr(24'h000010, 8'h00, 3'd0, 0, "R2 no program after bad unlock");

    // R2: address bits above the 11-bit index are ignored
    wr(24'h010AAA, 8'hAA, 3'd0, 0, "R2 alias unlock0");
    wr(24'h010554, 8'h55, 3'd0, 0, "R2 alias unlock1");
    wr(U0, 8'h90, 3'd2, 0, "R2 R3 autoselect via aliased unlock");
    wr(24'h0, 8'hF0, 3'd0, 0, "R7 reset from autoselect");

    // R3: unknown command byte
    unl(0);
    wr(U0, 8'h77, 3'd0, 0, "R3 unknown command");
    wr(U0, 8'hA0, 3'd0, 0, "R3 no command without unlock");

    // R8: query from read
    wr(QA, 8'h98, 3'd3, 0, "R8 query entry");
    wr(24'h0, 8'h12, 3'd0, 0, "R8 other write leaves query");
    wr(QA, 8'h98, 3'd3, 0, "R8 query entry again");
    wr(24'h0, 8'hF0, 3'd0, 0, "R7 reset from query");

    // R8 R7: query via autoselect
    unl(0);
    wr(U0, 8'h90, 3'd2, 0, "R3 autoselect");
    wr(QA, 8'h98, 3'd3, 0, "R8 autoselect query entry");
    wr(24'h0, 8'hF0, 3'd2, 0, "R7 reset returns to autoselect");
    wr(24'h0, 8'hF0, 3'd0, 0, "R7 reset from autoselect");

    // R5: bypass programming
    unl(0);
    wr(U0, 8'h20, 3'd0, 1, "R5 bypass entry");
    wr(24'h000222, 8'hA0, 3'd1, 1, "R5 command address unchecked");
    step(1, 0, 24'h000040, 8'h0F, 8'hFF, 3'd0, 1, 5'b10000, 24'h000040, 8'h0F, "R5 R4 bypass program");
    wr(24'h0, 8'hA0, 3'd1, 1, "R5 back at command step");
    step(1, 0, 24'h000042, 8'hF0, 8'hAA, 3'd0, 1, 5'b10000, 24'h000042, 8'hA0, "R4 F0 as program data");
    wr(24'h0, 8'h90, 3'd2, 1, "R5 autoselect in bypass");
    wr(24'h0, 8'h00, 3'd0, 0, "R5 bypass exit");
    wr(24'h0, 8'hA0, 3'd0, 0, "R5 no bypass after exit");
    unl(0);
    wr(U0, 8'h20, 3'd0, 1, "R5 bypass entry");
    wr(24'h0, 8'hF0, 3'd0, 0, "R7 reset clears bypass");

    // R6 R11: chip erase
    unl(0);
    wr(U0, 8'h80, 3'd0, 0, "R6 erase setup");
    unl(0);
    step(1, 0, U0, 8'h10, 8'hFF, 3'd4, 0, 5'b01000, '0, 8'h0, "R6 chip erase");
    wr(24'h0, 8'h00, 3'd4, 0, "R11 write ignored in chip erase");
    wr(24'h0, 8'hF0, 3'd4, 0, "R7 reset ignored in chip erase");
    step(0, 1, '0, 8'h0, 8'hFF, 3'd0, 0, 5'b0, '0, 8'h0, "R11 chip erase done");
    unl(0);
    wr(U0, 8'h80, 3'd0, 0, "R6 erase setup");
    unl(0);
    wr(24'h000100, 8'h10, 3'd0, 0, "R6 chip erase wrong address");

    // R6 R10: sector erase with open window
    erase_window = 1;
    unl(0);
    wr(U0, 8'h80, 3'd0, 0, "R6 erase setup");
    unl(0);
    step(1, 0, 24'h002000, 8'h30, 8'hFF, 3'd5, 0, 5'b00100, 24'h002000, 8'h0, "R6 sector erase");
    step(1, 0, 24'h004000, 8'h30, 8'hFF, 3'd5, 0, 5'b00100, 24'h004000, 8'h0, "R10 extra sector");
    wr(24'h0, 8'h44, 3'd0, 0, "R10 other data in window");

    // R10 R9: closed window, suspend, resume
    unl(0);
    wr(U0, 8'h80, 3'd0, 0, "R6 erase setup");
    unl(0);
    step(1, 0, 24'h006000, 8'h30, 8'hFF, 3'd5, 0, 5'b00100, 24'h006000, 8'h0, "R6 sector erase");
    erase_window = 0;
    wr(24'h0, 8'h12, 3'd5, 0, "R10 write ignored when window closed");
    wr(24'h0, 8'hF0, 3'd5, 0, "R7 reset ignored in sector erase");
    step(1, 0, '0, 8'hB0, 8'hFF, 3'd0, 0, 5'b00010, '0, 8'h0, "R10 suspend");
    erase_suspended = 1;
    wr(24'h0, 8'hB0, 3'd0, 0, "R9 suspend ignored in read");
    unl(0);
    wr(U0, 8'h80, 3'd0, 0, "R6 erase setup");
    unl(0);
    wr(24'h0, 8'h30, 3'd0, 0, "R6 erase refused while suspended");
    step(1, 0, '0, 8'h30, 8'hFF, 3'd5, 0, 5'b00001, '0, 8'h0, "R9 resume");
    erase_suspended = 0;
    step(0, 1, '0, 8'h0, 8'hFF, 3'd0, 0, 5'b0, '0, 8'h0, "R10 sector erase done");
    wr(24'h0, 8'h30, 3'd0, 0, "R9 resume without suspended erase");

    // R10 R5: sector erase under bypass
    unl(0);
    wr(U0, 8'h20, 3'd0, 1, "R5 bypass entry");
    wr(24'h0, 8'h80, 3'd0, 1, "R5 erase setup in bypass");
    unl(1);
    step(1, 0, 24'h000800, 8'h30, 8'hFF, 3'd5, 1, 5'b00100, 24'h000800, 8'h0, "R6 bypass sector erase");
    wr(24'h0, 8'h00, 3'd5, 1, "R12 hold in sector erase");
    step(0, 1, '0, 8'h0, 8'hFF, 3'd0, 1, 5'b0, '0, 8'h0, "R10 done returns to command step");
    wr(24'h0, 8'hA0, 3'd1, 1, "R10 command step after erase");
    step(1, 0, 24'h000008, 8'hFF, 8'h0F, 3'd0, 1, 5'b10000, 24'h000008, 8'h0F, "R4 program in bypass");
    wr(24'h0, 8'hF0, 3'd0, 0, "R7 reset clears bypass");

    // R12: idle cycles change nothing
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== 3'd0 || bypass_on !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle: mode=%0d byp=%0b expected mode=0 byp=0", mode, bypass_on);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule